// File: doc/BRIEF.md
# Fractional-Step PWM Channel with Staged Update

This block is one pulse-width modulation channel driven by a single 32-bit configuration word. It has no period counter. Every clock, an N-bit phase accumulator adds a programmable step and wraps modulo 2^N, so the output frequency is about clk × step / 2^N. The upper eight bits of the phase are compared against an 8-bit off-time divisor. The output is high while the phase sits above the divisor, so a divisor of 0 gives an almost fully-on waveform and a divisor of 255 keeps the output low.

Software writes the step and the divisor into staging and sets an update-request flag in the same word. The hardware moves the staged values into the active registers at the next cycle boundary, which is the clock on which the phase wraps, and clears the flag there. While the flag is still set, any write to the word is ignored, so software polls the flag before it writes again. The enable bit acts at once. With the channel disabled, the phase is held at zero and every clock counts as a boundary, so a staged update always completes within a bounded time.

Top module: `frac_pwm`

## Requirements
- R1: Bit 31 of the word is the enable and takes effect on the clock that writes it. While it is clear, pwm_out is 0 and the phase is held at zero.
- R2: Bit 30 is the update request. On a cycle boundary with the request set, the staged step and divisor become active and the request clears. Before that boundary the active values do not change.
- R3: A cycle boundary is the clock on which phase + active step carries out of N bits. While the channel is disabled, or while the active step is zero, every clock is a boundary.
- R4: A write that arrives while bit 30 reads 1 has no effect on any field: enable, request, step or divisor.
- R5: pwm_out is 1 exactly when the channel is enabled and phase[N-1:N-8] is strictly greater than the active divisor.
- R6: The step field is bits [8+N-1:8] and the divisor is bits [7:0]. While enabled, the phase advances by the active step each clock, modulo 2^N. With N=10 this gives an output period of 1024/step clocks.
- R7: A read returns the enable in bit 31, the live request in bit 30, and the staged step and divisor in their field positions. All other bits read 0.
- R8: After reset the word reads 0 and pwm_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Configuration word to write |
| rd_data | output | 32 | Current configuration word |
| pwm_out | output | 1 | PWM waveform |

## Verification
The hardest case to reach is a write that lands while an update is still pending on a running channel. The bench makes this case easy to hit by choosing a small step of 8, which stretches the cycle to 128 clocks, and then sends a second, different word a few clocks after raising the request. It then reads back that the staged fields still hold the first word. It counts the clocks until the request clears and checks that this count stays within one output cycle. After the request clears, it checks that the waveform follows the first word.

// File: rtl/pwm_cfg_pkg.sv
package pwm_cfg_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned EN_BIT   = 31;
  localparam int unsigned REQ_BIT  = 30;
  localparam int unsigned STEP_LSB = 8;
  localparam int unsigned DIV_W    = 8;
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_cfg_pkg::*;
#(
  parameter int unsigned STEP_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic                boundary,
  output logic                enable,
  output logic                req_pending,
  output logic [STEP_W-1:0]   step_stg,
  output logic [DIV_W-1:0]    div_stg,
  output logic [STEP_W-1:0]   step_act,
  output logic [DIV_W-1:0]    div_act
);
  logic              en_d, req_d;
  logic [STEP_W-1:0] step_stg_d, step_act_d;
  logic [DIV_W-1:0]  div_stg_d, div_act_d;
  logic              accept_wr, transfer;

  assign accept_wr = wr_en && !req_pending;
  assign transfer  = boundary && req_pending;

  always_comb begin
    en_d       = enable;
    req_d      = req_pending;
    step_stg_d = step_stg;
    div_stg_d  = div_stg;
    step_act_d = step_act;
    div_act_d  = div_act;
    if (accept_wr) begin
      en_d       = wr_data[EN_BIT];
      req_d      = wr_data[REQ_BIT];
      step_stg_d = wr_data[STEP_LSB +: STEP_W];
      div_stg_d  = wr_data[DIV_W-1:0];
    end else if (transfer) begin
      req_d      = 1'b0;
      step_act_d = step_stg;
      div_act_d  = div_stg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable      <= 1'b0;
      req_pending <= 1'b0;
      step_stg    <= '0;
      div_stg     <= '0;
      step_act    <= '0;
      div_act     <= '0;
    end else begin
      enable      <= en_d;
      req_pending <= req_d;
      step_stg    <= step_stg_d;
      div_stg     <= div_stg_d;
      step_act    <= step_act_d;
      div_act     <= div_act_d;
    end
  end

  // R4: a write while the request is pending leaves every field unchanged
  a_r4_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && req_pending) |=> ($stable(step_stg) && $stable(div_stg) && $stable(enable)));

  // R2: request holds until a boundary
  a_r2_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pending && !boundary) |=> req_pending);

  // R2: active values move only on a transfer
  a_r2_active_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(boundary && req_pending) |=> ($stable(step_act) && $stable(div_act)));
endmodule

// File: rtl/pwm_phase_acc.sv
module pwm_phase_acc #(
  parameter int unsigned STEP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [STEP_W-1:0] step_act,
  output logic [STEP_W-1:0] phase,
  output logic              boundary
);
  logic [STEP_W:0]   sum;
  logic [STEP_W-1:0] phase_d;

  assign sum      = {1'b0, phase} + {1'b0, step_act};
  assign boundary = !enable || (step_act == '0) || sum[STEP_W];

  always_comb begin
    if (enable) phase_d = sum[STEP_W-1:0];
    else        phase_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase_d;
  end

  // R1: phase held at zero while disabled
  a_r1_phase_held: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (phase == '0));

  // R6: phase advances by the step modulo 2^N while enabled
  a_r6_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> (phase == STEP_W'($past(phase) + $past(step_act))));
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
  import pwm_cfg_pkg::*;
#(
  parameter int unsigned STEP_W = 10
) (
  input  logic              enable,
  input  logic [STEP_W-1:0] phase,
  input  logic [DIV_W-1:0]  div_act,
  output logic              pwm_out
);
  localparam int unsigned TOP_LSB = STEP_W - DIV_W;
  logic [DIV_W-1:0] phase_top;

  assign phase_top = phase[TOP_LSB +: DIV_W];
  assign pwm_out   = enable && (phase_top > div_act);
endmodule

// File: rtl/frac_pwm.sv
module frac_pwm
  import pwm_cfg_pkg::*;
#(
  parameter int unsigned STEP_W = 10
) (
  input  logic        clk,
  input  logic        arst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        pwm_out
);
  localparam int unsigned PAD_W = WORD_W - 2 - STEP_W - DIV_W;

  logic              rst_n;
  logic              enable, req_pending, boundary;
  logic [STEP_W-1:0] step_stg, step_act, phase;
  logic [DIV_W-1:0]  div_stg, div_act;

  pwm_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  pwm_cfg_regs #(.STEP_W(STEP_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .boundary    (boundary),
    .enable      (enable),
    .req_pending (req_pending),
    .step_stg    (step_stg),
    .div_stg     (div_stg),
    .step_act    (step_act),
    .div_act     (div_act)
  );

  pwm_phase_acc #(.STEP_W(STEP_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .step_act (step_act),
    .phase    (phase),
    .boundary (boundary)
  );

  pwm_compare #(.STEP_W(STEP_W)) u_cmp (
    .enable  (enable),
    .phase   (phase),
    .div_act (div_act),
    .pwm_out (pwm_out)
  );

  assign rd_data = {enable, req_pending, {PAD_W{1'b0}}, step_stg, div_stg};

  // R1: output low while disabled
  a_r1_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[EN_BIT] |-> !pwm_out);

  // R3: disabled channel completes a pending request on the next clock
  a_r3_idle_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[EN_BIT] && rd_data[REQ_BIT] && !wr_en) |=> !rd_data[REQ_BIT]);
endmodule

// File: tb/sim_frac_pwm.sv
module sim_frac_pwm;
  localparam int N = 10;

  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm_out;

  int n_tests = 0;
  int n_fail  = 0;

  // stimulus table: {step[9:0], divisor[7:0], expected high clocks per period}
  localparam int NV = 6;
  localparam logic [25:0] VEC [NV] = '{
    {10'd256, 8'd0,   8'd3},
    {10'd512, 8'd0,   8'd1},
    {10'd128, 8'd100, 8'd4},
    {10'd64,  8'd255, 8'd0},
    {10'd32,  8'd127, 8'd16},
    {10'd128, 8'd0,   8'd7}
  };

  frac_pwm #(.STEP_W(N)) u0 (
    .clk     (clk),
    .arst_n  (arst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pwm_out (pwm_out)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] word(input logic en, input logic req,
                                       input int step, input int dv);
    return {en, req, 12'h0, step[9:0], dv[7:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic count_high(input int cycles, output int hi);
    hi = 0;
    for (int i = 0; i < cycles; i++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
  endtask

  // load a config with the channel disabled, then enable it
  task automatic start(input int step, input int dv);
    wr(word(1'b0, 1'b1, step, dv));
    @(negedge clk);
    wr(word(1'b1, 1'b0, step, dv));
  endtask

  initial begin
    #3_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int hi, cnt;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: reset state
    check("R8 word", rd_data, 32'h0);
    check("R8 pwm", {31'h0, pwm_out}, 32'h0);

    // R7: reserved bits read zero; fields in place
    wr(32'hFFFF_FFFF);
    check("R7 readback", rd_data, 32'hC003_FFFF);
    @(negedge clk);
    check("R3 zero-step clears request", {31'h0, rd_data[30]}, 32'h0);
    count_high(8, hi);
    check("R5 divisor 255 keeps low", hi, 0);
    wr(32'h0);
    check("R1 disable word", rd_data, 32'h0);

    // R5/R6: table of step/divisor patterns
    for (int v = 0; v < NV; v++) begin
      int step, dv, exp_hi, per;
      step   = int'(VEC[v][25:16]);
      dv     = int'(VEC[v][15:8]);
      exp_hi = int'(VEC[v][7:0]);
      per    = 1024 / step;
      start(step, dv);
      count_high(2 * per, hi);
      check($sformatf("R5/R6 vec%0d high count", v), hi, 2 * exp_hi);
      wr(word(1'b0, 1'b0, step, dv));
      @(negedge clk);
    end

    // R2/R4: request pending on a running channel, second write ignored
    start(8, 50);
    repeat (10) @(negedge clk);
    wr(word(1'b1, 1'b1, 16, 20));
    check("R2 staged with request", rd_data, word(1'b1, 1'b1, 16, 20));
    wr(word(1'b0, 1'b0, 256, 200));
    check("R4 write ignored", rd_data, word(1'b1, 1'b1, 16, 20));
    cnt = 0;
    while (rd_data[30] && cnt < 300) begin
      @(negedge clk);
      cnt++;
    end
    check("R3 request clears within one cycle", {31'h0, (cnt >= 1 && cnt <= 128)}, 32'h1);
    count_high(64, hi);
    check("R2 new config active after boundary", hi, 58);

    // R1: disable gates output at once and stays low
    wr(word(1'b0, 1'b0, 16, 0));
    count_high(20, hi);
    check("R1 output low while disabled", hi, 0);

    // R3: enabled with zero active step, request clears next clock
    start(0, 0);
    count_high(4, hi);
    check("R6 zero step holds phase", hi, 0);
    wr(word(1'b1, 1'b1, 256, 0));
    @(negedge clk);
    check("R3 zero-step boundary", {31'h0, rd_data[30]}, 32'h0);
    count_high(4, hi);
    check("R5 after zero-step transfer", hi, 3);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule